// File: doc/BRIEF.md
# Oversampling Decimator with Resolution Extension

This block takes a stream of unsigned ADC samples, each qualified by a valid strobe, and turns every block of 4^p accepted samples into one wider output word. The block total is divided by 2^p rather than by the sample count, so the sub-LSB information spread across the block by input noise stays in the low bits. Each output word therefore carries p more bits of resolution than the input. The output rate is the input rate divided by 4^p. With 12-bit samples at 1 MS/s and p = 1, it produces 13-bit words at 250 kS/s.

The extension p is chosen at run time in the range 0 to `P_MAX`. The block reads it only when a block begins, so it can be changed at any time without corrupting a block that is already in progress. A level run control aligns block boundaries. While run is low the block discards any partial block and ignores incoming samples. The first sample accepted after run goes high opens a new block. Each output word is right-aligned, so for a constant input the code doubles with each extra bit. The word comes with a one-cycle valid pulse and with the p that produced it.

Top module: `ovs_decimator`

## Requirements
- R1: During and directly after reset, out_valid_o is 0 and out_data_o is 0.
- R2: A sample is accepted only in a cycle with run_i = 1 and in_valid_i = 1. out_valid_o is 1 in exactly the cycle after the 4^p-th accepted sample of a block, and never otherwise.
- R3: The output word equals floor(S / 2^p), where S is the unsigned sum of the block's 4^p samples. It is zero-extended to SAMPLE_W + P_MAX bits.
- R4: The accumulator holds the full sum without loss. At p = P_MAX, a block of all-ones samples gives (4^P_MAX·(2^SAMPLE_W−1)) >> P_MAX exactly. With the defaults this is 32760.
- R5: p_sel_i is captured with the first accepted sample of a block and holds for that whole block. A change mid-block applies from the next block. out_p_o reports the p used for the current output word.
- R6: With in_valid_i held high, the sample that follows a block's last sample is the first sample of the next block. No sample is lost or counted twice.
- R7: out_valid_o is a one-cycle pulse per block. out_data_o and out_p_o hold their values until the next block completes.
- R8: While run_i = 0, samples are ignored and the partial block is discarded, and out_valid_o is 0 in the following cycle. After run_i returns to 1, the next accepted sample starts a fresh block.
- R9: For a constant input, each extra bit doubles the output code. A sample value of 1250 reads 1250, 2500 and 5000 at p = 0, 1 and 2.
- R10: At p = 0, every accepted sample appears unchanged on out_data_o in the next cycle, with out_valid_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = accumulate, 0 = discard partial block and ignore samples |
| p_sel_i | input | PW | Requested extra bits p (0..P_MAX), read at block start |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | SAMPLE_W | Unsigned ADC sample |
| out_valid_o | output | 1 | One-cycle pulse when a block completes |
| out_data_o | output | SAMPLE_W+P_MAX | Block sum shifted right by p, right-aligned |
| out_p_o | output | PW | p used for the word on out_data_o |

## Verification
The hardest situations to reach from the ports are the ones where two controls line up on one block edge. One is a p change landing on the first sample of a block. Another is run dropping on the very cycle that would have closed a block. A third is the wrap from a block's last sample straight into the next block's first. Directed sequences place a p change two samples into a block, drop run one sample short of completion, and hold valid high across several back-to-back blocks. A long stretch of seeded random traffic then adds sparse valid gaps, occasional run drops and frequent p changes. The bench model keeps its own count and sum, so each block edge is checked against the requirements.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  // Width of the block sum for w-bit samples and up to pmax extra bits.
  function automatic int acc_width(input int w, input int pmax);
    return w + 2 * pmax;
  endfunction

  // Width of the right-aligned output word.
  function automatic int out_width(input int w, input int pmax);
    return w + pmax;
  endfunction
endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl #(
  parameter int P_MAX = 3,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          in_valid_i,
  input  logic [PW-1:0] p_sel_i,
  output logic          take_o,
  output logic          first_o,
  output logic          last_o,
  output logic [PW-1:0] p_eff_o
);
  localparam int CW = 2 * P_MAX;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] p_q, p_d;
  logic [PW-1:0] p_req;
  logic [CW-1:0] lim;

  // Clamp requests beyond P_MAX only when the select width can encode them.
  generate
    if ((1 << PW) > (P_MAX + 1)) begin : g_clamp
      assign p_req = (int'(p_sel_i) > P_MAX) ? PW'(P_MAX) : p_sel_i;
    end else begin : g_noclamp
      assign p_req = p_sel_i;
    end
  endgenerate

  always_comb begin
    take_o  = run_i & in_valid_i;
    first_o = (cnt_q == '0);
    p_eff_o = first_o ? p_req : p_q;
    lim     = {CW{1'b1}} >> (2 * (P_MAX - int'(p_eff_o)));
    last_o  = (cnt_q == lim);
  end

  always_comb begin
    cnt_d = cnt_q;
    p_d   = p_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (take_o) begin
      cnt_d = last_o ? '0 : cnt_q + CW'(1);
      if (first_o) p_d = p_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      p_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      p_q   <= p_d;
    end
  end
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int P_MAX    = 3,
  parameter int PW       = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take_i,
  input  logic                        first_i,
  input  logic                        last_i,
  input  logic [PW-1:0]               p_eff_i,
  input  logic [SAMPLE_W-1:0]         in_data_i,
  output logic                        out_valid_o,
  output logic [SAMPLE_W+P_MAX-1:0]   out_data_o,
  output logic [PW-1:0]               out_p_o
);
  localparam int ACC_W = acc_width(SAMPLE_W, P_MAX);
  localparam int OUT_W = out_width(SAMPLE_W, P_MAX);

  logic [ACC_W-1:0] acc_q, acc_d, sum_full;
  logic [OUT_W-1:0] dat_d;
  logic [PW-1:0]    p_d;
  logic             vld_d;

  always_comb begin
    // A block's first sample replaces whatever the accumulator holds.
    sum_full = (first_i ? '0 : acc_q) + ACC_W'(in_data_i);
    acc_d    = take_i ? sum_full : acc_q;
    vld_d    = take_i & last_i;
    dat_d    = vld_d ? OUT_W'(sum_full >> p_eff_i) : out_data_o;
    p_d      = vld_d ? p_eff_i : out_p_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_p_o     <= '0;
    end else begin
      acc_q       <= acc_d;
      out_valid_o <= vld_d;
      out_data_o  <= dat_d;
      out_p_o     <= p_d;
    end
  end
endmodule

// File: rtl/ovs_decimator.sv
module ovs_decimator
  import ovs_pkg::*;
#(
  parameter  int SAMPLE_W = 12,
  parameter  int P_MAX    = 3,
  localparam int PW       = $clog2(P_MAX + 1),
  localparam int OUT_W    = out_width(SAMPLE_W, P_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic [PW-1:0]       p_sel_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                out_valid_o,
  output logic [OUT_W-1:0]    out_data_o,
  output logic [PW-1:0]       out_p_o
);
  logic          take;
  logic          blk_first;
  logic          blk_last;
  logic [PW-1:0] p_eff;

  ovs_ctrl #(.P_MAX(P_MAX), .PW(PW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .in_valid_i (in_valid_i),
    .p_sel_i    (p_sel_i),
    .take_o     (take),
    .first_o    (blk_first),
    .last_o     (blk_last),
    .p_eff_o    (p_eff)
  );

  ovs_accum #(.SAMPLE_W(SAMPLE_W), .P_MAX(P_MAX), .PW(PW)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .first_i     (blk_first),
    .last_i      (blk_last),
    .p_eff_i     (p_eff),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_p_o     (out_p_o)
  );
endmodule

// File: rtl/ovs_decimator_chk.sv
module ovs_decimator_chk #(
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 15,
  parameter int PW       = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_i,
  input logic [PW-1:0]       p_sel_i,
  input logic                in_valid_i,
  input logic [SAMPLE_W-1:0] in_data_i,
  input logic                out_valid_o,
  input logic [OUT_W-1:0]    out_data_o,
  input logic                blk_first
);
  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> $stable(out_data_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !out_valid_o);

  // R2
  accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(run_i && in_valid_i));

  // R10
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && in_valid_i && blk_first && p_sel_i == '0)
      |=> (out_valid_o && out_data_o == OUT_W'($past(in_data_i))));
endmodule

bind ovs_decimator ovs_decimator_chk #(
  .SAMPLE_W (SAMPLE_W),
  .OUT_W    (OUT_W),
  .PW       (PW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_i       (run_i),
  .p_sel_i     (p_sel_i),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .blk_first   (blk_first)
);

// File: tb/ovs_decimator_tb.sv
module ovs_decimator_tb_top;
  localparam int SW    = 12;
  localparam int PM    = 3;
  localparam int PW    = $clog2(PM + 1);
  localparam int OW    = SW + PM;

  logic          clk;
  logic          rst_n;
  logic          run_i;
  logic [PW-1:0] p_sel_i;
  logic          in_valid_i;
  logic [SW-1:0] in_data_i;
  logic          out_valid_o;
  logic [OW-1:0] out_data_o;
  logic [PW-1:0] out_p_o;

  int total = 0;
  int fails = 0;
  string cur_tag = "R3";

  // Bench model state, derived from the requirements.
  int m_cnt = 0;
  longint m_sum = 0;
  int m_p = 0;
  int m_out = 0;
  int m_outp = 0;
  bit exp_v = 0;

  ovs_decimator #(.SAMPLE_W(SW), .P_MAX(PM)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .p_sel_i     (p_sel_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_p_o     (out_p_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int expected_word(input longint s, input int p);
    return int'(s >> p);
  endfunction

  task automatic check_eq(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, sample at next negedge.
  task automatic step(input bit v, input int d, input bit r, input int p);
    run_i      = r;
    in_valid_i = v;
    in_data_i  = SW'(d);
    p_sel_i    = PW'(p);
    @(posedge clk);
    exp_v = 0;
    if (!r) begin
      m_cnt = 0;
      m_sum = 0;
    end else if (v) begin
      if (m_cnt == 0) m_p = p;
      m_sum += d;
      m_cnt++;
      if (m_cnt == (1 << (2 * m_p))) begin
        exp_v  = 1;
        m_out  = expected_word(m_sum, m_p);
        m_outp = m_p;
        m_cnt  = 0;
        m_sum  = 0;
      end
    end
    @(negedge clk);
    check_eq("R2", out_valid_o, exp_v);
    if (exp_v) begin
      check_eq(cur_tag, out_data_o, m_out);
      check_eq("R5", out_p_o, m_outp);
    end else begin
      check_eq("R7", out_data_o, m_out);
    end
  endtask

  task automatic block(input int n, input int d, input int p);
    for (int i = 0; i < n; i++) step(1, d, 1, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; run_i = 0; in_valid_i = 0; in_data_i = '0; p_sel_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1", out_valid_o, 0);
    check_eq("R1", out_data_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", out_valid_o, 0);

    // R10 pass-through at p = 0
    cur_tag = "R10";
    step(1, 17, 1, 0);
    check_eq("R10", out_data_o, 17);
    step(1, 4095, 1, 0);
    check_eq("R10", out_data_o, 4095);

    // R9 constant input doubles per extra bit
    cur_tag = "R9";
    block(1, 1250, 0);
    check_eq("R9", out_data_o, 1250);
    block(4, 1250, 1);
    check_eq("R9", out_data_o, 2500);
    block(16, 1250, 2);
    check_eq("R9", out_data_o, 5000);

    // R7 hold across idle cycles
    for (int i = 0; i < 5; i++) step(0, 99, 1, 3);
    check_eq("R7", out_data_o, 5000);

    // R4 full-scale block at p = P_MAX
    cur_tag = "R4";
    block(64, 4095, 3);
    check_eq("R4", out_data_o, 32760);
    check_eq("R4", out_p_o, 3);

    // R5 p changed two samples into a block
    cur_tag = "R5";
    step(1, 10, 1, 1);
    step(1, 11, 1, 1);
    step(1, 12, 1, 2);
    step(1, 13, 1, 2);
    check_eq("R5", out_data_o, (10 + 11 + 12 + 13) >> 1);
    check_eq("R5", out_p_o, 1);
    block(16, 7, 2);
    check_eq("R5", out_data_o, 28);
    check_eq("R5", out_p_o, 2);

    // R8 run drops one sample short of completion
    cur_tag = "R8";
    block(3, 900, 1);
    step(1, 900, 0, 1);
    check_eq("R8", out_valid_o, 0);
    step(1, 5, 1, 1);
    check_eq("R8", out_valid_o, 0);
    block(3, 5, 1);
    check_eq("R8", out_data_o, 10);

    // R6 back-to-back blocks, distinct data per sample
    cur_tag = "R6";
    for (int i = 0; i < 64; i++) step(1, (i * 37) % 4096, 1, 2);

    // R3 seeded random traffic
    cur_tag = "R3";
    begin
      int p = 1;
      for (int i = 0; i < 6000; i++) begin
        if (($urandom % 23) == 0) p = int'($urandom % (PM + 1));
        step(($urandom % 10) < 7, int'($urandom % 4096), ($urandom % 60) != 0, p);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule